// File: doc/BRIEF.md
# Status-Driven Bus Command Generator

This block turns a bus master's three cycle-status lines into the command strobes a memory and I/O bus needs: an address latch enable pulse, and active-low read and write strobes, one pair for memory and one pair for I/O. It has no ready input. The master stretches a transfer by holding a non-passive status code for more clocks. The controller follows those codes and keeps the active strobe low for as long as the cycle lasts.

A change of status from passive (3'b111) to any other code starts a cycle. The controller records the cycle type in the first clock (T1) and pulses the latch enable for the first half of that clock. It then walks through T2, one or more T3/wait clocks, and T4. Write strobes switch on rising clock edges. Read strobes switch on falling edges, half a clock later than writes. This gives data time to settle on reads and releases write data early.

Top module: `bus_cmd_gen`

## Requirements
- R1: When reset is applied, every strobe output is high and the latch enable is low. This holds after the clock edges that follow reset, including when reset cuts into a cycle.
- R2: The latch enable goes high on the first rising edge where the status is sampled non-passive, which begins T1. It goes low on the next falling edge, in the middle of T1. It stays low for the rest of the cycle.
- R3: In a write cycle, the matching write strobe goes low on the rising edge that begins T2.
- R4: In a read cycle, the matching read strobe is still high at the start of T2. It goes low on the falling edge in the middle of T2.
- R5: The status codes decode as follows: 3'b001 is an I/O read, 3'b010 an I/O write, 3'b100 and 3'b101 memory reads, and 3'b110 a memory write. Codes 3'b000 and 3'b011 pulse the latch enable but drive no strobe. At most one strobe is low at any time.
- R6: While the status stays non-passive at the rising edges after T2, the cycle stays in the wait state. The active strobe stays low with no release.
- R7: A write strobe goes high on the first rising edge where the status is sampled passive, which begins T4.
- R8: A read strobe stays low at the start of T4. It goes high on the falling edge in the middle of T4.
- R9: If the status is non-passive at the rising edge that ends T4, a new T1 begins at once, with no idle clock in between.
- R10: The cycle type is taken from the status only when T1 begins. A different non-passive code shown later in the same cycle does not change which strobe is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; rising and falling edges both used |
| rst | input | 1 | Synchronous active-high reset |
| status | input | 3 | Cycle-status code from the bus master, 3'b111 passive |
| ale | output | 1 | Address latch enable, high in first half of T1 |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| io_rd_n | output | 1 | Active-low I/O read strobe |
| io_wr_n | output | 1 | Active-low I/O write strobe |

## Verification
The hardest cases to reach from the ports are those where the status moves at an unusual moment. One is a non-passive code that appears during T4, which must chain straight into a new T1. Another is a second non-passive code shown partway through a wait state. The bench drives the status only in the second half of each clock, so it can place each change before a chosen rising edge. It samples the outputs in both halves of every clock, which exposes the half-clock offset between read and write strobes.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

    localparam int STAT_W = 3;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t ST_INTA    = 3'b000;
    localparam stat_t ST_IO_RD   = 3'b001;
    localparam stat_t ST_IO_WR   = 3'b010;
    localparam stat_t ST_HALT    = 3'b011;
    localparam stat_t ST_FETCH   = 3'b100;
    localparam stat_t ST_MEM_RD  = 3'b101;
    localparam stat_t ST_MEM_WR  = 3'b110;
    localparam stat_t ST_PASSIVE = 3'b111;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_TW,
        PH_T4
    } phase_e;

    typedef struct packed {
        logic is_mem;
        logic is_io;
        logic is_rd;
        logic is_wr;
    } kind_t;

    localparam kind_t KIND_NONE = '0;

    function automatic logic stat_active(stat_t s);
        return s != ST_PASSIVE;
    endfunction

    function automatic kind_t decode_kind(stat_t s);
        kind_t k;
        k = KIND_NONE;
        case (s)
            ST_IO_RD:           begin k.is_io = 1'b1;  k.is_rd = 1'b1; end
            ST_IO_WR:           begin k.is_io = 1'b1;  k.is_wr = 1'b1; end
            ST_FETCH, ST_MEM_RD: begin k.is_mem = 1'b1; k.is_rd = 1'b1; end
            ST_MEM_WR:          begin k.is_mem = 1'b1; k.is_wr = 1'b1; end
            default:            k = KIND_NONE;
        endcase
        return k;
    endfunction

    function automatic logic in_strobe_phase(phase_e p);
        return (p == PH_T2) || (p == PH_TW);
    endfunction

endpackage

// File: rtl/bcg_status_decoder.sv
module bcg_status_decoder
    import bus_cmd_pkg::*;
(
    input  stat_t status,
    output logic  active,
    output kind_t kind
);

    always_comb begin
        active = stat_active(status);
        kind   = decode_kind(status);
    end

endmodule

// File: rtl/bcg_cycle_fsm.sv
module bcg_cycle_fsm
    import bus_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  kind_t  kind_in,
    output phase_e phase_q,
    output phase_e phase_d,
    output kind_t  kind_q,
    output kind_t  kind_d
);

    always_comb begin
        phase_d = phase_q;
        kind_d  = kind_q;
        case (phase_q)
            PH_IDLE, PH_T4: begin
                if (active) begin
                    phase_d = PH_T1;
                    kind_d  = kind_in;
                end else begin
                    phase_d = PH_IDLE;
                    kind_d  = KIND_NONE;
                end
            end
            PH_T1:        phase_d = PH_T2;
            PH_T2, PH_TW: phase_d = active ? PH_TW : PH_T4;
            default: begin
                phase_d = PH_IDLE;
                kind_d  = KIND_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            kind_q  <= KIND_NONE;
        end else begin
            phase_q <= phase_d;
            kind_q  <= kind_d;
        end
    end

    // R2 / R9: a non-passive code seen while idle or in T4 opens T1 next
    assert_cycle_start_R2: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_IDLE || phase_q == PH_T4) && active) |=> (phase_q == PH_T1));

    // R6 / R10: the wait state persists and the latched type does not move
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TW && active) |=> (phase_q == PH_TW && $stable(kind_q)));

endmodule

// File: rtl/bcg_strobe_gen.sv
module bcg_strobe_gen
    import bus_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase_q,
    input  phase_e phase_d,
    input  kind_t  kind_q,
    input  kind_t  kind_d,
    output logic   ale,
    output logic   mem_rd_n,
    output logic   mem_wr_n,
    output logic   io_rd_n,
    output logic   io_wr_n
);

    logic ale_rise_q;
    logic ale_fall_q;
    logic mem_wr_q;
    logic io_wr_q;
    logic mem_rd_q;
    logic io_rd_q;

    // rising-edge half: latch enable start and write strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            ale_rise_q <= 1'b0;
            mem_wr_q   <= 1'b0;
            io_wr_q    <= 1'b0;
        end else begin
            ale_rise_q <= (phase_d == PH_T1);
            mem_wr_q   <= in_strobe_phase(phase_d) && kind_d.is_mem && kind_d.is_wr;
            io_wr_q    <= in_strobe_phase(phase_d) && kind_d.is_io  && kind_d.is_wr;
        end
    end

    // falling-edge half: latch enable end and read strobes
    always_ff @(negedge clk) begin
        if (rst) begin
            ale_fall_q <= 1'b0;
            mem_rd_q   <= 1'b0;
            io_rd_q    <= 1'b0;
        end else begin
            ale_fall_q <= (phase_q == PH_T1);
            mem_rd_q   <= in_strobe_phase(phase_q) && kind_q.is_mem && kind_q.is_rd;
            io_rd_q    <= in_strobe_phase(phase_q) && kind_q.is_io  && kind_q.is_rd;
        end
    end

    always_comb begin
        ale      = ale_rise_q && !ale_fall_q;
        mem_rd_n = !mem_rd_q;
        mem_wr_n = !mem_wr_q;
        io_rd_n  = !io_rd_q;
        io_wr_n  = !io_wr_q;
    end

    // R5: never more than one command strobe active
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd_q, mem_wr_q, io_rd_q, io_wr_q}));

    // R7: during T4 no write strobe is active
    assert_wr_released_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_T4) |-> (!mem_wr_q && !io_wr_q));

    // R1: a reset edge leaves the write strobes inactive
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!mem_wr_q && !io_wr_q && !ale_rise_q));

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
    import bus_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] status,
    output logic              ale,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n
);

    logic   active;
    kind_t  kind_in;
    phase_e phase_q;
    phase_e phase_d;
    kind_t  kind_q;
    kind_t  kind_d;

    bcg_status_decoder u_dec (
        .status (status),
        .active (active),
        .kind   (kind_in)
    );

    bcg_cycle_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .kind_in (kind_in),
        .phase_q (phase_q),
        .phase_d (phase_d),
        .kind_q  (kind_q),
        .kind_d  (kind_d)
    );

    bcg_strobe_gen u_strb (
        .clk      (clk),
        .rst      (rst),
        .phase_q  (phase_q),
        .phase_d  (phase_d),
        .kind_q   (kind_q),
        .kind_d   (kind_d),
        .ale      (ale),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n)
    );

endmodule

// File: tb/bus_cmd_gen_tb.sv
`timescale 1ns/1ps
module bus_cmd_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] status = 3'b111;
    logic       ale, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [2:0] cur_code = 3'b111;

    always #2.5 clk = ~clk;

    bus_cmd_gen u_dut (
        .clk(clk), .rst(rst), .status(status), .ale(ale),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
    );

    task automatic tick_early(); @(posedge clk); #1; endtask
    task automatic tick_late();  @(negedge clk); #1; endtask

    function automatic bit code_rd(logic [2:0] c);
        return (c == 3'b001) || (c == 3'b100) || (c == 3'b101);
    endfunction
    function automatic bit code_wr(logic [2:0] c);
        return (c == 3'b010) || (c == 3'b110);
    endfunction

    // rd_on / wr_on: whether the strobe for cur_code should be active now
    task automatic check(input string tag, input bit ale_e, input bit rd_on, input bit wr_on);
        logic [4:0] got, exp;
        bit is_mem;
        is_mem = cur_code[2];
        exp = {ale_e,
               !(rd_on && code_rd(cur_code) && is_mem),
               !(wr_on && code_wr(cur_code) && is_mem),
               !(rd_on && code_rd(cur_code) && !is_mem),
               !(wr_on && code_wr(cur_code) && !is_mem)};
        got = {ale, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s code=%b t=%0t {ale,memr_n,memw_n,ior_n,iow_n} actual=%b expected=%b",
                     tag, cur_code, $time, got, exp);
        end
    endtask

    // entered in the second half of an idle clock or of T4
    task automatic run_cycle(input logic [2:0] code, input int waits, input string t1_tag,
                             input bit swap, input logic [2:0] swap_code, input bit chain);
        bit rd, wr;
        rd = code_rd(code);
        wr = code_wr(code);
        status = code;
        tick_early(); cur_code = code;
        check(t1_tag, 1'b1, 1'b0, 1'b0);            // T1 first half
        tick_late();  check("R2", 1'b0, 1'b0, 1'b0); // T1 second half
        tick_early(); check("R3", 1'b0, 1'b0, wr);   // T2 first half, read still high
        tick_late();  check("R4", 1'b0, rd, wr);     // T2 second half
        for (int i = 0; i <= waits; i++) begin
            tick_early(); check(swap ? "R10" : "R6", 1'b0, rd, wr);
            tick_late();  check(swap ? "R10" : "R6", 1'b0, rd, wr);
            if (swap && i == 0) status = swap_code;
            if (i == waits) status = 3'b111;
        end
        tick_early(); check("R7", 1'b0, rd, 1'b0);   // T4 first half
        tick_late();  check("R8", 1'b0, 1'b0, 1'b0); // T4 second half
        if (!chain) begin
            tick_early(); check("R5", 1'b0, 1'b0, 1'b0);
            tick_late();  check("R5", 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic test_reset();
        repeat (3) tick_early();
        tick_late();
        check("R1", 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        tick_early(); check("R1", 1'b0, 1'b0, 1'b0);
        tick_late();
    endtask

    task automatic test_basic_kinds();
        run_cycle(3'b101, 0, "R2", 1'b0, 3'b111, 1'b0);
        run_cycle(3'b110, 0, "R2", 1'b0, 3'b111, 1'b0);
        run_cycle(3'b001, 0, "R5", 1'b0, 3'b111, 1'b0);
        run_cycle(3'b010, 0, "R5", 1'b0, 3'b111, 1'b0);
        run_cycle(3'b100, 0, "R5", 1'b0, 3'b111, 1'b0);
    endtask

    task automatic test_no_strobe_codes();
        run_cycle(3'b011, 1, "R5", 1'b0, 3'b111, 1'b0);
        run_cycle(3'b000, 0, "R5", 1'b0, 3'b111, 1'b0);
    endtask

    task automatic test_wait_states();
        run_cycle(3'b101, 4, "R6", 1'b0, 3'b111, 1'b0);
        run_cycle(3'b010, 3, "R6", 1'b0, 3'b111, 1'b0);
    endtask

    task automatic test_back_to_back();
        run_cycle(3'b110, 1, "R2", 1'b0, 3'b111, 1'b1);
        run_cycle(3'b001, 0, "R9", 1'b0, 3'b111, 1'b1);
        run_cycle(3'b010, 2, "R9", 1'b0, 3'b111, 1'b0);
    endtask

    task automatic test_late_code_change();
        run_cycle(3'b101, 2, "R10", 1'b1, 3'b110, 1'b0);
        run_cycle(3'b010, 2, "R10", 1'b1, 3'b001, 1'b0);
    endtask

    task automatic test_reset_mid_cycle();
        status = 3'b101;
        tick_early(); cur_code = 3'b101;
        tick_late(); tick_early(); tick_late();
        check("R4", 1'b0, 1'b1, 1'b0);
        rst = 1'b1; status = 3'b111;
        tick_early(); tick_late();
        check("R1", 1'b0, 1'b0, 1'b0);
        tick_early(); rst = 1'b0;
        tick_late();
        tick_early(); check("R1", 1'b0, 1'b0, 1'b0);
        tick_late();
    endtask

    initial begin
        test_reset();
        test_basic_kinds();
        test_no_strobe_codes();
        test_wait_states();
        test_back_to_back();
        test_late_code_change();
        test_reset_mid_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired, all requirements: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule